// File: doc/BRIEF.md
# Video crosspoint routing controller

This block holds the digital routing state of an analog video crosspoint that has eight inputs and six outputs. A host sends 16-bit configuration words one at a time through a single-cycle write strobe. Each accepted word picks one output, names the input that drives it, sets that output's enable and sets the clamp-disable flag of the named input. The block drives, for every output, a 3-bit input-select code and an enable. It also drives one clamp-disable flag per input. An input carrying chroma or a multiplexed analog component signal has its clamp flag set high. An input carrying a normal composite or RGB signal has it low. Any number of outputs may select the same input.

After reset the route held in the switch fabric is unknown. The block therefore runs a two-state machine. In state `ST_UNDEF` it records which outputs have been written and holds every output enable low. On the clock edge where a write completes the set of all six outputs, it takes the transition `UNDEF_TO_READY` into state `ST_READY`. From then on `config_valid` is high, the stored enables reach the output pins, and one word is enough to change one route. The transition `READY_HOLD` keeps the machine in `ST_READY` until the next reset.

Word layout:
- bits [2:0] select the output index.
- bits [5:3] select the input index.
- bit 6 is the output enable.
- bit 7 is the clamp-off flag of the selected input.
- bits [15:8] are reserved and have no effect.

Top module: `xpt_route_ctrl`

## Requirements
- R1: A write whose output index (bits [2:0]) is 0 to 5 sets that output's `out_sel` field (bits [3k+2:3k] for output k) to the word's bits [5:3]. The change is visible in the cycle after the write edge.
- R2: Several outputs may select the same input at the same time. Routing one output never changes the select code of another output.
- R3: After reset, every `out_sel` field, every `out_en` bit, every `clamp_off` bit, `config_valid` and `cmd_err` are all zero.
- R4: `config_valid` rises in the cycle after the write edge of the word that completes the set of all six outputs. Repeated writes to the same output do not count twice. Once high, `config_valid` stays high until reset.
- R5: While `config_valid` is low, every bit of `out_en` is zero, whatever enables have been written.
- R6: While `config_valid` is high, `out_en[k]` equals bit 6 of the last accepted word for output k.
- R7: An accepted word sets `clamp_off[i]` to its bit 7, where i is the word's bits [5:3]. The clamp flags of all other inputs are unchanged.
- R8: A word with an output index of 6 or 7 changes no select code, enable, clamp flag or output-coverage tracking. `cmd_err` is high for exactly the one cycle after that write edge.
- R9: Reserved bits [15:8] of a word have no effect on any output.
- R10: With the write strobe low, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; one word per high cycle |
| wr_data | input | 16 | Configuration word |
| out_sel | output | 18 | Input-select code per output, 3 bits each, output 0 in the lowest bits |
| out_en | output | 6 | Enable per output |
| clamp_off | output | 8 | Clamp-disable flag per input |
| config_valid | output | 1 | High once every output has been written since reset |
| cmd_err | output | 1 | One-cycle pulse after a word with an output index of 6 or 7 |

## Verification
The bench builds the block with its default sizes of eight inputs and six outputs. With these sizes the 3-bit output index has two unused codes, 6 and 7. The bench can therefore drive the rejected-word path both before and after the configuration becomes known, and it can use every input code.

The bench covers several cases:
- It routes one input to three outputs at once.
- It rewrites an output before coverage is complete, to show that a repeated write does not fill the coverage early.
- It writes words with the reserved byte set.

Its reference model tracks the written set and the enables behaviourally and checks every output on every clock.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    typedef enum logic {
        ST_UNDEF = 1'b0,
        ST_READY = 1'b1
    } xpt_state_e;

endpackage

// File: rtl/xpt_word_decode.sv
module xpt_word_decode #(
    parameter int N_IN   = 8,
    parameter int N_OUT  = 6,
    parameter int WORD_W = 16
) (
    input  logic                         wr_en,
    input  logic [WORD_W-1:0]            wr_data,
    output logic [$clog2(N_IN)-1:0]      in_idx,
    output logic                         en_bit,
    output logic                         clamp_bit,
    output logic                         hit,
    output logic                         bad,
    output logic [N_OUT-1:0]             hit_onehot
);

    localparam int OIW     = $clog2(N_OUT);
    localparam int IIW     = $clog2(N_IN);
    localparam int FLD_END = OIW + IIW + 2;

    logic [OIW-1:0] out_idx;
    logic           unused_rsvd;

    assign out_idx     = wr_data[OIW-1:0];
    assign in_idx      = wr_data[OIW +: IIW];
    assign en_bit      = wr_data[OIW + IIW];
    assign clamp_bit   = wr_data[OIW + IIW + 1];
    assign unused_rsvd = ^wr_data[WORD_W-1:FLD_END];

    always_comb begin
        bad = wr_en && ((int'(out_idx) >= N_OUT) || (int'(in_idx) >= N_IN));
        hit = wr_en && !bad;
    end

    genvar k;
    generate
        for (k = 0; k < N_OUT; k++) begin : g_hit
            assign hit_onehot[k] = hit && (out_idx == OIW'(k));
        end
    endgenerate

endmodule

// File: rtl/xpt_route_bank.sv
module xpt_route_bank #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_OUT-1:0]              hit_onehot,
    input  logic [$clog2(N_IN)-1:0]       in_idx,
    input  logic                          en_bit,
    output logic [N_OUT*$clog2(N_IN)-1:0] out_sel,
    output logic [N_OUT-1:0]              route_en
);

    localparam int IIW = $clog2(N_IN);

    genvar k;
    generate
        for (k = 0; k < N_OUT; k++) begin : g_out
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_sel[k*IIW +: IIW] <= '0;
                    route_en[k]           <= 1'b0;
                end else if (hit_onehot[k]) begin
                    out_sel[k*IIW +: IIW] <= in_idx;
                    route_en[k]           <= en_bit;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/xpt_clamp_bank.sv
module xpt_clamp_bank #(
    parameter int N_IN = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hit,
    input  logic [$clog2(N_IN)-1:0] in_idx,
    input  logic                    clamp_bit,
    output logic [N_IN-1:0]         clamp_off
);

    localparam int IIW = $clog2(N_IN);

    genvar i;
    generate
        for (i = 0; i < N_IN; i++) begin : g_in
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    clamp_off[i] <= 1'b0;
                end else if (hit && (in_idx == IIW'(i))) begin
                    clamp_off[i] <= clamp_bit;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/xpt_route_ctrl.sv
module xpt_route_ctrl
    import xpt_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int N_OUT  = 6,
    parameter int WORD_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [N_OUT*$clog2(N_IN)-1:0] out_sel,
    output logic [N_OUT-1:0]              out_en,
    output logic [N_IN-1:0]               clamp_off,
    output logic                          config_valid,
    output logic                          cmd_err
);

    localparam int IIW = $clog2(N_IN);

    xpt_state_e         state_q, state_d;
    logic [N_OUT-1:0]   written_q;
    logic [N_OUT-1:0]   hit_onehot;
    logic [N_OUT-1:0]   route_en;
    logic [IIW-1:0]     in_idx;
    logic               en_bit, clamp_bit, hit, bad;

    xpt_word_decode #(.N_IN(N_IN), .N_OUT(N_OUT), .WORD_W(WORD_W)) u_dec (
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .in_idx     (in_idx),
        .en_bit     (en_bit),
        .clamp_bit  (clamp_bit),
        .hit        (hit),
        .bad        (bad),
        .hit_onehot (hit_onehot)
    );

    xpt_route_bank #(.N_IN(N_IN), .N_OUT(N_OUT)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_onehot (hit_onehot),
        .in_idx     (in_idx),
        .en_bit     (en_bit),
        .out_sel    (out_sel),
        .route_en   (route_en)
    );

    xpt_clamp_bank #(.N_IN(N_IN)) u_clamp (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .in_idx     (in_idx),
        .clamp_bit  (clamp_bit),
        .clamp_off  (clamp_off)
    );

    // State register with coverage tracking and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_UNDEF;
            written_q <= '0;
            cmd_err   <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_err <= bad;
            if (state_q == ST_UNDEF) begin
                written_q <= written_q | hit_onehot;
            end
        end
    end

    // Next state: UNDEF_TO_READY on full coverage, READY_HOLD afterwards
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNDEF: if ((written_q | hit_onehot) == {N_OUT{1'b1}}) state_d = ST_READY;
            ST_READY: state_d = ST_READY;
        endcase
    end

    // Outputs
    always_comb begin
        config_valid = (state_q == ST_READY);
        out_en       = config_valid ? route_en : '0;
    end

endmodule

// File: rtl/xpt_route_chk.sv
module xpt_route_chk #(
    parameter int N_IN   = 8,
    parameter int N_OUT  = 6,
    parameter int WORD_W = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [WORD_W-1:0]             wr_data,
    input logic [N_OUT*$clog2(N_IN)-1:0] out_sel,
    input logic [N_OUT-1:0]              out_en,
    input logic [N_IN-1:0]               clamp_off,
    input logic                          config_valid,
    input logic                          cmd_err
);

    localparam int OIW = $clog2(N_OUT);
    localparam int IIW = $clog2(N_IN);

    logic bad_word;
    assign bad_word = wr_en && (int'(wr_data[OIW-1:0]) >= N_OUT);

    assert_en_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !config_valid |-> (out_en == '0));

    assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        config_valid |=> config_valid);

    assert_valid_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(config_valid) |-> $past(wr_en));

    assert_bad_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_word |=> (cmd_err && $stable(out_sel) && $stable(clamp_off) && $stable(out_en)));

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(bad_word));

    genvar k;
    generate
        for (k = 0; k < N_OUT; k++) begin : g_chk
            assert_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (wr_data[OIW-1:0] == OIW'(k)))
                |=> (out_sel[k*IIW +: IIW] == $past(wr_data[OIW +: IIW])));
        end
    endgenerate

endmodule

bind xpt_route_ctrl xpt_route_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .out_sel      (out_sel),
    .out_en       (out_en),
    .clamp_off    (clamp_off),
    .config_valid (config_valid),
    .cmd_err      (cmd_err)
);

// File: tb/xpt_route_ctrl_test.sv
`timescale 1ns/1ps
module xpt_route_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [17:0] out_sel;
    logic [5:0]  out_en;
    logic [7:0]  clamp_off;
    logic        config_valid;
    logic        cmd_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int exp_sel [6];
    int exp_en  [6];
    int written [6];
    int exp_clamp [8];
    int exp_valid = 0;
    int exp_err = 0;

    always #2.5 clk = ~clk;

    xpt_route_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .out_sel(out_sel), .out_en(out_en), .clamp_off(clamp_off),
        .config_valid(config_valid), .cmd_err(cmd_err)
    );

    function automatic logic [15:0] mk(int o, int i, int en, int cl, int rsvd = 0);
        return {rsvd[7:0], cl[0], en[0], i[2:0], o[2:0]};
    endfunction

    task automatic chk(bit ok, string tag, string fld, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, fld, act, exp);
        end
    endtask

    task automatic compare(string tag);
        for (int k = 0; k < 6; k++) begin
            int a;
            int e;
            a = int'(out_sel[k*3 +: 3]);
            chk(a == exp_sel[k], tag, $sformatf("R1 out_sel[%0d]", k), a, exp_sel[k]);
            e = exp_valid ? exp_en[k] : 0;
            chk(int'(out_en[k]) == e, tag,
                $sformatf("%s out_en[%0d]", exp_valid ? "R6" : "R5", k), int'(out_en[k]), e);
        end
        for (int i = 0; i < 8; i++)
            chk(int'(clamp_off[i]) == exp_clamp[i], tag, $sformatf("R7 clamp_off[%0d]", i),
                int'(clamp_off[i]), exp_clamp[i]);
        chk(int'(config_valid) == exp_valid, tag, "R4 config_valid", int'(config_valid), exp_valid);
        chk(int'(cmd_err) == exp_err, tag, "R8 cmd_err", int'(cmd_err), exp_err);
    endtask

    task automatic model_apply(bit we, logic [15:0] d);
        int o;
        int i;
        int all;
        o = int'(d[2:0]);
        i = int'(d[5:3]);
        exp_err = (we && o >= 6) ? 1 : 0;
        if (we && o < 6) begin
            exp_sel[o] = i;
            exp_en[o]  = int'(d[6]);
            exp_clamp[i] = int'(d[7]);
            written[o] = 1;
            all = 1;
            for (int k = 0; k < 6; k++) if (written[k] == 0) all = 0;
            if (all == 1) exp_valid = 1;
        end
    endtask

    task automatic step(bit we, logic [15:0] d, string tag);
        @(negedge clk);
        compare(tag);
        wr_en   = we;
        wr_data = d;
        @(posedge clk);
        #1;
        model_apply(we, d);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        for (int k = 0; k < 6; k++) begin exp_sel[k] = 0; exp_en[k] = 0; written[k] = 0; end
        for (int i = 0; i < 8; i++) exp_clamp[i] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 reset state
        step(0, '0, "R3");
        step(0, '0, "R3");

        // Partial configuration; enables must stay hidden (R5)
        step(1, mk(0, 3, 1, 0), "R1");
        step(1, mk(1, 3, 1, 0), "R2");
        step(1, mk(2, 5, 0, 1), "R7");
        step(1, mk(6, 2, 1, 1), "R8");
        step(1, mk(7, 4, 1, 1), "R8");
        step(1, mk(3, 7, 1, 0), "R5");
        step(1, mk(4, 0, 1, 0), "R5");
        step(1, mk(2, 5, 1, 0), "R4");
        step(0, '0, "R5");
        step(0, '0, "R5");

        // Final output completes coverage (R4)
        step(1, mk(5, 3, 1, 1), "R4");
        step(0, '0, "R6");
        @(negedge clk);
        chk(out_sel[2:0] == out_sel[5:3] && out_sel[5:3] == out_sel[17:15], "R2",
            "shared input", int'(out_sel[17:15]), 3);

        // Reserved bits ignored (R9)
        step(1, mk(4, 6, 0, 1, 8'hA5), "R9");
        step(1, mk(1, 2, 1, 0, 8'hFF), "R9");
        step(0, '0, "R9");

        // Rejected word after configuration known (R8)
        step(1, mk(6, 1, 0, 0), "R8");
        step(1, mk(7, 6, 1, 0, 8'h3C), "R8");
        step(0, '0, "R8");

        // Idle holds (R10)
        for (int n = 0; n < 5; n++) step(0, 16'hFFFF, "R10");

        // Sweep all input codes (R1, R6, R7)
        for (int i = 0; i < 8; i++) step(1, mk(i % 6, i, i & 1, (i >> 1) & 1), "R1");
        step(0, '0, "R6");
        step(0, '0, "R10");

        // Mid-run reset returns to unknown configuration (R3)
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        for (int k = 0; k < 6; k++) begin exp_sel[k] = 0; exp_en[k] = 0; written[k] = 0; end
        for (int i = 0; i < 8; i++) exp_clamp[i] = 0;
        exp_valid = 0;
        exp_err = 0;
        @(negedge clk);
        rst_n = 1'b1;
        step(0, '0, "R3");
        step(1, mk(0, 1, 1, 0), "R5");
        step(0, '0, "R5");

        finish_run();
    end

endmodule